// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor. It holds an accumulator, a hidden second-operand register and five status flags. The accumulator is loaded from a data port. The hidden operand register is loaded through its own strobe and cannot be read back. An execute strobe applies the selected operation to the two registers. The operations are add, subtract, AND, OR and XOR.

On every valid execute, the result replaces the accumulator and all five flags are recomputed. The flags are sign, zero, half carry out of the low nibble, even parity, and carry. On subtract, the carry flag means a borrow. The flags leave the block packed into one byte at fixed bit positions, so a neighbouring block can push or test them.

Top module: `alu8_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the accumulator reads 00h and the flag byte reads 02h.
- R2: Operation codes on op_sel are 0 add (A+T), 1 subtract (A−T), 2 AND, 3 OR and 4 XOR. The result appears on acc_out one clock edge after exec is sampled high.
- R3: The flag byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R4: After an execute, S equals bit 7 of the result, Z is 1 exactly when the result is 00h, and P is 1 exactly when the result has an even number of 1 bits.
- R5: On add, CY is the carry out of bit 7 and AC is the carry out of bit 3 into bit 4. For example, 88h + 99h gives 21h with flag byte 17h.
- R6: On subtract, CY is 1 when A < T (a borrow). AC is the bit-3 carry of A + ~T + 1, which is 1 when A[3:0] ≥ T[3:0].
- R7: AND sets AC to 1 and clears CY. OR and XOR clear both AC and CY.
- R8: acc_ld loads acc_in into the accumulator and leaves the flags unchanged. If exec is high with a valid code in the same cycle, the result wins and acc_in is dropped.
- R9: When tmp_ld and exec are high in the same cycle, the operation uses the operand register's old value. The new value is used from the next execute on.
- R10: exec with a reserved code (5, 6 or 7) changes neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code for execute |
| exec | input | 1 | Execute strobe |
| tmp_ld | input | 1 | Load strobe for the hidden operand register |
| tmp_in | input | 8 | Operand data |
| acc_ld | input | 1 | Accumulator load strobe |
| acc_in | input | 8 | Accumulator load data |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 8 | Packed flag byte |

## Verification
Two pairs of actions can land in the same cycle. The first pair is an execute and an accumulator load. The second pair is an execute and an operand load. The bench raises both strobes on the same clock edge. For the accumulator pair, it checks that the accumulator holds the operation's result and not acc_in. For the operand pair, it checks that the result uses the old operand value. It then runs one more execute to confirm that the new operand value was captured.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes an 8-bit flag byte whose layout is fixed by neighbouring logic.
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_AC = 4;
    localparam int FB_P  = 2;
    localparam int FB_ONE = 1;
    localparam int FB_CY = 0;
endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor: computes a+b or a-b (as a + ~b + 1).
// Returns carry (borrow on subtract) and the low-nibble carry.
// Assumes DATA_W is at least 8; the nibble is fixed at 4 bits.
module alu8_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              ac
);
    localparam int NIB_W = 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_w;
    logic [NIB_W:0]    nib_w;

    // Full-width and nibble sums with the operand inverted for subtract.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        nib_w = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, sub};
        res   = sum_w[DATA_W-1:0];
        cy    = sub ? ~sum_w[DATA_W] : sum_w[DATA_W];
        ac    = nib_w[NIB_W];
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: per-bit AND, OR or XOR of two operands.
// Assumes sel is one of the logical operation codes; others give AND.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           sel,
    output logic [DATA_W-1:0] res
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Per-bit selection of the logical function.
        always_comb begin
            unique case (sel)
                OP_OR:   res[i] = a[i] | b[i];
                OP_XOR:  res[i] = a[i] ^ b[i];
                default: res[i] = a[i] & b[i];
            endcase
        end
    end
endmodule

// File: rtl/alu8_flag_pack.sv
// Packs the five stored flags into the fixed 8-bit layout.
// Assumes the constant bits: bit 1 reads one, bits 5 and 3 read zero.
module alu8_flag_pack
    import alu8_pkg::*;
(
    input  alu_flags_t  flags,
    output logic [7:0]  byte_o
);
    // Place each flag at its bit position.
    always_comb begin
        byte_o         = 8'h00;
        byte_o[FB_S]   = flags.s;
        byte_o[FB_Z]   = flags.z;
        byte_o[FB_AC]  = flags.ac;
        byte_o[FB_P]   = flags.p;
        byte_o[FB_ONE] = 1'b1;
        byte_o[FB_CY]  = flags.cy;
    end
endmodule

// File: rtl/alu8_flags.sv
// Top: accumulator, hidden operand register and flag register around the
// arithmetic and logic units. An execute with a valid code overrides an
// accumulator load. An operand load in the same cycle takes effect afterwards.
// Assumes a synchronous active-low reset.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              exec,
    input  logic              tmp_ld,
    input  logic [DATA_W-1:0] tmp_in,
    input  logic              acc_ld,
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [7:0]        flags_out
);
    logic [DATA_W-1:0] acc_q, tmp_q;
    alu_flags_t        flg_q, flg_d;
    alu_op_e           op;
    logic              op_ok, do_exec, is_arith, is_sub;
    logic [DATA_W-1:0] ar_res, lg_res, res;
    logic              ar_cy, ar_ac;

    // Decode the operation code and check that it is valid.
    always_comb begin
        op       = alu_op_e'(op_sel);
        op_ok    = (op_sel <= 3'd4);
        do_exec  = exec & op_ok;
        is_sub   = (op == OP_SUB);
        is_arith = (op == OP_ADD) | is_sub;
    end

    alu8_arith #(.DATA_W(DATA_W)) u_arith (
        .a(acc_q), .b(tmp_q), .sub(is_sub),
        .res(ar_res), .cy(ar_cy), .ac(ar_ac)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a(acc_q), .b(tmp_q), .sel(op), .res(lg_res)
    );

    // Select the result and compute the next flags.
    always_comb begin
        res      = is_arith ? ar_res : lg_res;
        flg_d.s  = res[DATA_W-1];
        flg_d.z  = (res == '0);
        flg_d.p  = ~^res;
        flg_d.cy = is_arith ? ar_cy : 1'b0;
        flg_d.ac = is_arith ? ar_ac : (op == OP_AND);
    end

    // Accumulator: an execute wins over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (do_exec) acc_q <= res;
        else if (acc_ld)  acc_q <= acc_in;
    end

    // Hidden operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmp_q <= '0;
        else if (tmp_ld) tmp_q <= tmp_in;
    end

    // Flag register, written only by a valid execute.
    always_ff @(posedge clk) begin
        if (!rst_n)       flg_q <= '0;
        else if (do_exec) flg_q <= flg_d;
    end

    alu8_flag_pack u_pack (.flags(flg_q), .byte_o(flags_out));

    assign acc_out = acc_q;

    // R8: a load without an execute moves acc_in into the accumulator.
    assert_acc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && !do_exec) |=> (acc_out == $past(acc_in)));
    // R8: the flags are left alone when there is no valid execute.
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !do_exec |=> $stable(flags_out));
    // R10: with no load and no valid execute, the accumulator holds.
    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_exec && !acc_ld) |=> $stable(acc_out));
    // R4: after an execute the zero flag matches the new accumulator.
    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_exec |=> (flags_out[FB_Z] == (acc_out == '0)));
    // R4: after an execute the parity flag matches the new accumulator.
    assert_parity_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_exec |=> (flags_out[FB_P] == ~^acc_out));
    // R4: after an execute the sign flag equals the top bit of the accumulator.
    assert_sign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_exec |=> (flags_out[FB_S] == acc_out[DATA_W-1]));
    // R7: a logical operation leaves CY clear.
    assert_logic_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_exec && !is_arith) |=> !flags_out[FB_CY]);
endmodule

// File: tb/test_alu8_flags.sv
// Directed bench: each task drives one scenario and checks its own results.
module test_alu8_flags;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic       exec = 1'b0, tmp_ld = 1'b0, acc_ld = 1'b0;
    logic [7:0] tmp_in = 8'h00, acc_in = 8'h00;
    logic [7:0] acc_out, flags_out;
    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .exec(exec),
        .tmp_ld(tmp_ld), .tmp_in(tmp_in), .acc_ld(acc_ld), .acc_in(acc_in),
        .acc_out(acc_out), .flags_out(flags_out)
    );

    // Reference model written from the requirements: returns {acc, flags}.
    function automatic logic [15:0] model(input logic [2:0] op,
                                          input logic [7:0] a, input logic [7:0] t);
        logic [8:0] w;
        logic [7:0] r;
        logic cy, ac;
        cy = 1'b0; ac = 1'b0; r = 8'h00;
        case (op)
            3'd0: begin w = {1'b0,a} + {1'b0,t}; r = w[7:0]; cy = w[8];
                        ac = ({1'b0,a[3:0]} + {1'b0,t[3:0]}) > 5'd15; end
            3'd1: begin r = a - t; cy = (a < t); ac = (a[3:0] >= t[3:0]); end
            3'd2: begin r = a & t; ac = 1'b1; end
            3'd3: r = a | t;
            default: r = a ^ t;
        endcase
        model = {r, r[7], (r == 8'h00), 1'b0, ac, 1'b0, ~^r, 1'b1, cy};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_acc(input logic [7:0] v);
        acc_in = v; acc_ld = 1'b1; step(); acc_ld = 1'b0;
    endtask

    task automatic load_tmp(input logic [7:0] v);
        tmp_in = v; tmp_ld = 1'b1; step(); tmp_ld = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op);
        op_sel = op; exec = 1'b1; step(); exec = 1'b0;
    endtask

    // Loads both operands, executes and compares with the model.
    task automatic one_op(input string req, input logic [2:0] op,
                          input logic [7:0] a, input logic [7:0] t);
        logic [15:0] e;
        e = model(op, a, t);
        load_acc(a); load_tmp(t); run_op(op);
        check(req, acc_out, e[15:8]);
        check(req, flags_out, e[7:0]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        check("R1", acc_out, 8'h00);
        check("R1", flags_out, 8'h02);
        check("R3", flags_out & 8'h2A, 8'h02);
    endtask

    task automatic t_add();
        one_op("R5", 3'd0, 8'h88, 8'h99);
        check("R5", flags_out, 8'h17);
        one_op("R5", 3'd0, 8'hFF, 8'h01);
        one_op("R2", 3'd0, 8'h12, 8'h34);
        one_op("R4", 3'd0, 8'h70, 8'h10);
    endtask

    task automatic t_sub();
        one_op("R6", 3'd1, 8'h05, 8'h07);
        one_op("R6", 3'd1, 8'h07, 8'h05);
        one_op("R6", 3'd1, 8'h42, 8'h42);
        one_op("R6", 3'd1, 8'h30, 8'h01);
    endtask

    task automatic t_logic();
        one_op("R7", 3'd2, 8'hF0, 8'h3C);
        one_op("R7", 3'd3, 8'hA0, 8'h05);
        one_op("R7", 3'd4, 8'h5A, 8'h5A);
        one_op("R7", 3'd2, 8'h0F, 8'hF0);
        one_op("R3", 3'd3, 8'h81, 8'h00);
    endtask

    // Load and execute together: the result wins; operand load comes after.
    task automatic t_concurrent();
        logic [15:0] e;
        load_acc(8'h10); load_tmp(8'h03);
        e = model(3'd0, 8'h10, 8'h03);
        acc_in = 8'hEE; acc_ld = 1'b1; op_sel = 3'd0; exec = 1'b1;
        tmp_in = 8'h20; tmp_ld = 1'b1;
        step();
        acc_ld = 1'b0; exec = 1'b0; tmp_ld = 1'b0;
        check("R8", acc_out, e[15:8]);
        check("R9", flags_out, e[7:0]);
        e = model(3'd0, 8'h13, 8'h20);
        run_op(3'd0);
        check("R9", acc_out, e[15:8]);
        load_acc(8'hC3);
        check("R8", acc_out, 8'hC3);
        check("R8", flags_out, e[7:0]);
    endtask

    task automatic t_reserved();
        logic [7:0] f;
        load_acc(8'h5C); load_tmp(8'h11);
        run_op(3'd1);
        f = flags_out;
        for (int c = 5; c < 8; c++) begin
            run_op(3'(c));
            check("R10", acc_out, 8'h4B);
            check("R10", flags_out, f);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_concurrent();
        t_reserved();
        finish_run();
    end
endmodule